// File: doc/BRIEF.md
# Coprocessor Mailbox Command Engine

This engine runs one complete command exchange with an embedded coprocessor for the host. On a start strobe it reads a command select. It builds a five-word checksummed message and writes it into the coprocessor's message RAM through a simple register-bus master port. It then rings a doorbell mailbox and polls the return mailbox at a fixed interval until the coprocessor answers or the poll budget runs out.

When the coprocessor answers, the engine reads the five reply words back and acknowledges by clearing the return mailbox. It then checks the reply checksum. The engine reports a status word and a small error index. It also decodes the reply's argument word into a pointer: a memory select, a byte offset and a flag for an invalid pointer type. A timeout takes the same path, except that no reply words are read.

The bus port raises `bus_req_o` with address, direction and write data. It holds them until `bus_ack_i` is seen for one cycle. In the acknowledge cycle, `bus_rdata_i` carries the read data.

Top module: `mbx_cmd_engine`

## Requirements
- R1: An accepted command writes five words to byte addresses 0x100, 0x104, 0x108, 0x10C and 0x110, in that order. The words are: header 1, opcode, argument count 1, argument, and a checksum that is the 32-bit sum of the other four. Select 0 uses opcode 1 and argument 1. Select 1 uses opcode 2 and argument 1. Select 2 uses opcode 2 and argument 2.
- R2: After the fifth message write, and never before it, the engine writes the value 1 to the doorbell at address 0x010. It does this exactly once per command.
- R3: The engine reads the return mailbox at address 0x014 and stops polling at the first nonzero value. After each read that returns zero, the bus stays idle for exactly POLL_INTERVAL cycles before the next poll read is issued.
- R4: Suppose POLL_LIMIT consecutive polls all read zero. The command then ends with status 0x8000_0010 and error index 5. No reply words are read, `resp_o` is all zero, and all pointer outputs are zero.
- R5: When the mailbox answers, the engine reads the five reply words from 0x100 to 0x110 in order. Word i appears on `resp_o[32*i +: 32]`.
- R6: Every command that rang the doorbell ends with a single write of 0 to 0x014. This write comes after all reply reads. `done_o` pulses for one cycle after the acknowledge of that write, and `busy_o` is low in that cycle.
- R7: If reply word 4 differs from the 32-bit sum of reply words 0 to 3, the status is 0x8000_0004 and the error index is 3. This holds whatever the mailbox value was.
- R8: Otherwise the status equals the nonzero mailbox value. The error index is 0 when the status is 1. In every other case it is one plus the position of the lowest set bit among status bits 30 to 0, or 0 if none of those bits is set.
- R9: Reply word 3 is split into a type in bits 31:28 and an offset in bits 27:0. Type 1 sets `ptr_sel_o` (message RAM). Type 0 clears it (data RAM). Any other type raises `ptr_fatal_o` and clears `ptr_sel_o`. `ptr_off_o` is bits 27:0 of word 3.
- R10: A start with select 3 (out of range) produces `done_o` one cycle later. The status is 0x8000_0002 and the error index is 2. No bus access is made and `busy_o` stays low.
- R11: `busy_o` rises in the cycle after an accepted start and stays high until `done_o`. A start strobe while busy is ignored. The bus is idle whenever `busy_o` is low.
- R12: After reset, `busy_o`, `done_o` and `bus_req_o` are low, and `status_o` and `err_idx_o` are zero.
- R13: Once `bus_req_o` is raised, the request, address and direction stay unchanged until the cycle in which `bus_ack_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe |
| cmd_sel_i | input | CMD_W | Command select (0..2 valid) |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 32 | Final status word |
| err_idx_o | output | 5 | Error index, 0 on success |
| resp_o | output | 160 | Five reply words, word 0 in the low bits |
| ptr_sel_o | output | 1 | Pointer addresses message RAM (1) or data RAM (0) |
| ptr_off_o | output | 28 | Pointer byte offset |
| ptr_fatal_o | output | 1 | Invalid pointer type in the reply |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | Bus write (1) or read (0) |
| bus_addr_o | output | ADDR_W | Bus byte address |
| bus_wdata_o | output | 32 | Bus write data |
| bus_rdata_i | input | 32 | Bus read data, valid with acknowledge |
| bus_ack_i | input | 1 | Bus acknowledge |

## Verification
The checker watches a few rules on every cycle. The bus must stay silent while idle, and a request must be held until it is acknowledged. `done_o` must be a single-cycle pulse with `busy_o` low. The error index must agree with a success or timeout status, and the fatal pointer flag must agree with the type field of reply word 3. The bench's scenarios cover everything else. These are the order and content of the message writes, doorbell placement, poll spacing and count, timeout at the exact poll budget, checksum override, status-to-index mapping for many codes, pointer decoding, rejection of an out-of-range select, and the start strobe being ignored while busy.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int WORD_W    = 32;
    localparam int MSG_WORDS = 5;
    localparam int PTR_OFF_W = 28;
    localparam int IDX_W     = 5;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [MSG_WORDS-1:0][WORD_W-1:0] msg_t;

    // byte offsets inside the coprocessor register window
    localparam int MSG_BASE     = 'h100;
    localparam int DOORBELL_OFS = 'h010;
    localparam int HOSTBOX_OFS  = 'h014;

    localparam word_t STATUS_OK    = 32'h0000_0001;
    localparam word_t ERR_FLAG     = 32'h8000_0000;
    localparam word_t CAUSE_INVAL  = 32'h0000_0002;
    localparam word_t CAUSE_CHKSUM = 32'h0000_0004;
    localparam word_t CAUSE_TMO    = 32'h0000_0010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_RING,
        ST_POLL,
        ST_WAIT,
        ST_FETCH,
        ST_ACK
    } state_e;

    // one plus position of lowest set bit in [30:0], zero if none
    function automatic logic [IDX_W-1:0] low_cause_idx(input word_t s);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = WORD_W - 2; i >= 0; i--) begin
            if (s[i]) r = IDX_W'(i + 1);
        end
        return r;
    endfunction

    function automatic word_t sum4(input msg_t m);
        return m[0] + m[1] + m[2] + m[3];
    endfunction

endpackage

// File: rtl/mbx_msg_rom.sv
module mbx_msg_rom
    import mbx_pkg::*;
#(
    parameter int CMD_W = 2
) (
    input  logic [CMD_W-1:0] cmd_i,
    output msg_t             msg_o
);
    word_t opcode;
    word_t arg0;

    always_comb begin
        opcode = '0;
        arg0   = '0;
        unique case (cmd_i)
            CMD_W'(0): begin opcode = 32'd1; arg0 = 32'd1; end
            CMD_W'(1): begin opcode = 32'd2; arg0 = 32'd1; end
            CMD_W'(2): begin opcode = 32'd2; arg0 = 32'd2; end
            default:   begin opcode = '0;    arg0 = '0;    end
        endcase
    end

    always_comb begin
        msg_o    = '0;
        msg_o[0] = 32'd1;
        msg_o[1] = opcode;
        msg_o[2] = 32'd1;
        msg_o[3] = arg0;
        msg_o[4] = sum4(msg_o);
    end

endmodule

// File: rtl/mbx_poll_timer.sv
module mbx_poll_timer #(
    parameter int POLL_INTERVAL = 500,
    parameter int POLL_LIMIT    = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic miss_i,
    output logic wait_done_o,
    output logic exhausted_o
);
    localparam int IW = $clog2(POLL_INTERVAL + 1);
    localparam int LW = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        logic [IW-1:0] wcnt;
        logic [LW-1:0] tries;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (clr_i) begin
            d.wcnt  = '0;
            d.tries = '0;
        end else if (miss_i) begin
            d.wcnt  = IW'(POLL_INTERVAL - 1);
            d.tries = q.tries + 1'b1;
        end else if (q.wcnt != '0) begin
            d.wcnt = q.wcnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wait_done_o = (q.wcnt == '0);
    assign exhausted_o = (q.tries == LW'(POLL_LIMIT));

endmodule

// File: rtl/mbx_resp_decode.sv
module mbx_resp_decode
    import mbx_pkg::*;
(
    input  msg_t                 resp_i,
    input  word_t                hostbox_i,
    input  logic                 tmo_i,
    output word_t                status_o,
    output logic [IDX_W-1:0]     err_idx_o,
    output logic                 ptr_sel_o,
    output logic [PTR_OFF_W-1:0] ptr_off_o,
    output logic                 ptr_fatal_o
);
    localparam int TYPE_W = WORD_W - PTR_OFF_W;

    logic              sum_bad;
    logic [TYPE_W-1:0] ptype;

    assign sum_bad = (sum4(resp_i) != resp_i[4]);
    assign ptype   = resp_i[3][WORD_W-1:PTR_OFF_W];

    always_comb begin
        if (tmo_i)        status_o = ERR_FLAG | CAUSE_TMO;
        else if (sum_bad) status_o = ERR_FLAG | CAUSE_CHKSUM;
        else              status_o = hostbox_i;
        err_idx_o = (status_o == STATUS_OK) ? '0 : low_cause_idx(status_o);
    end

    always_comb begin
        if (tmo_i) begin
            ptr_sel_o   = 1'b0;
            ptr_off_o   = '0;
            ptr_fatal_o = 1'b0;
        end else begin
            ptr_sel_o   = (ptype == TYPE_W'(1));
            ptr_off_o   = resp_i[3][PTR_OFF_W-1:0];
            ptr_fatal_o = (ptype > TYPE_W'(1));
        end
    end

endmodule

// File: rtl/mbx_cmd_engine.sv
module mbx_cmd_engine
    import mbx_pkg::*;
#(
    parameter int CMD_W         = 2,
    parameter int NUM_CMDS      = 3,
    parameter int ADDR_W        = 12,
    parameter int POLL_INTERVAL = 500,
    parameter int POLL_LIMIT    = 200000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [CMD_W-1:0]              cmd_sel_i,
    output logic                          busy_o,
    output logic                          done_o,
    output logic [31:0]                   status_o,
    output logic [4:0]                    err_idx_o,
    output logic [32*5-1:0]               resp_o,
    output logic                          ptr_sel_o,
    output logic [27:0]                   ptr_off_o,
    output logic                          ptr_fatal_o,
    output logic                          bus_req_o,
    output logic                          bus_we_o,
    output logic [ADDR_W-1:0]             bus_addr_o,
    output logic [31:0]                   bus_wdata_o,
    input  logic [31:0]                   bus_rdata_i,
    input  logic                          bus_ack_i
);
    localparam logic [2:0]        LAST_IDX = 3'(MSG_WORDS - 1);
    localparam logic [ADDR_W-1:0] A_MSG    = ADDR_W'(MSG_BASE);
    localparam logic [ADDR_W-1:0] A_DOOR   = ADDR_W'(DOORBELL_OFS);
    localparam logic [ADDR_W-1:0] A_HOST   = ADDR_W'(HOSTBOX_OFS);

    typedef struct packed {
        state_e                st;
        logic [2:0]            idx;
        logic                  busy;
        logic                  done;
        logic [CMD_W-1:0]      cmd;
        logic                  tmo;
        word_t                 hostbox;
        msg_t                  resp;
        word_t                 status;
        logic [IDX_W-1:0]      err;
        logic                  psel;
        logic [PTR_OFF_W-1:0]  poff;
        logic                  pfatal;
    } eng_t;

    eng_t d, q;

    msg_t                 tmpl;
    word_t                dec_status;
    logic [IDX_W-1:0]     dec_err;
    logic                 dec_psel;
    logic [PTR_OFF_W-1:0] dec_poff;
    logic                 dec_pfatal;
    logic                 tmr_clr;
    logic                 tmr_miss;
    logic                 tmr_wait_done;
    logic                 tmr_exhausted;
    logic [ADDR_W-1:0]    idx_addr;

    mbx_msg_rom #(.CMD_W(CMD_W)) u_rom (
        .cmd_i (q.cmd),
        .msg_o (tmpl)
    );

    mbx_resp_decode u_dec (
        .resp_i      (q.resp),
        .hostbox_i   (q.hostbox),
        .tmo_i       (q.tmo),
        .status_o    (dec_status),
        .err_idx_o   (dec_err),
        .ptr_sel_o   (dec_psel),
        .ptr_off_o   (dec_poff),
        .ptr_fatal_o (dec_pfatal)
    );

    mbx_poll_timer #(
        .POLL_INTERVAL (POLL_INTERVAL),
        .POLL_LIMIT    (POLL_LIMIT)
    ) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (tmr_clr),
        .miss_i      (tmr_miss),
        .wait_done_o (tmr_wait_done),
        .exhausted_o (tmr_exhausted)
    );

    assign idx_addr = A_MSG + ADDR_W'({q.idx, 2'b00});
    assign tmr_clr  = (q.st == ST_IDLE) && start_i;
    assign tmr_miss = (q.st == ST_POLL) && bus_ack_i && (bus_rdata_i == '0);

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        bus_req_o   = 1'b0;
        bus_we_o    = 1'b0;
        bus_addr_o  = '0;
        bus_wdata_o = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (32'(cmd_sel_i) < NUM_CMDS) begin
                        d.st      = ST_SEND;
                        d.idx     = '0;
                        d.busy    = 1'b1;
                        d.cmd     = cmd_sel_i;
                        d.tmo     = 1'b0;
                        d.hostbox = '0;
                        d.resp    = '0;
                    end else begin
                        d.done   = 1'b1;
                        d.status = ERR_FLAG | CAUSE_INVAL;
                        d.err    = low_cause_idx(CAUSE_INVAL);
                        d.resp   = '0;
                        d.psel   = 1'b0;
                        d.poff   = '0;
                        d.pfatal = 1'b0;
                    end
                end
            end
            ST_SEND: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = idx_addr;
                bus_wdata_o = tmpl[q.idx];
                if (bus_ack_i) begin
                    if (q.idx == LAST_IDX) d.st = ST_RING;
                    else                   d.idx = q.idx + 1'b1;
                end
            end
            ST_RING: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = A_DOOR;
                bus_wdata_o = 32'd1;
                if (bus_ack_i) d.st = ST_POLL;
            end
            ST_POLL: begin
                bus_req_o  = 1'b1;
                bus_addr_o = A_HOST;
                if (bus_ack_i) begin
                    if (bus_rdata_i != '0) begin
                        d.hostbox = bus_rdata_i;
                        d.idx     = '0;
                        d.st      = ST_FETCH;
                    end else begin
                        d.st = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (tmr_exhausted) begin
                    d.tmo = 1'b1;
                    d.st  = ST_ACK;
                end else if (tmr_wait_done) begin
                    d.st = ST_POLL;
                end
            end
            ST_FETCH: begin
                bus_req_o  = 1'b1;
                bus_addr_o = idx_addr;
                if (bus_ack_i) begin
                    d.resp[q.idx] = bus_rdata_i;
                    if (q.idx == LAST_IDX) d.st = ST_ACK;
                    else                   d.idx = q.idx + 1'b1;
                end
            end
            ST_ACK: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = A_HOST;
                bus_wdata_o = '0;
                if (bus_ack_i) begin
                    d.st     = ST_IDLE;
                    d.busy   = 1'b0;
                    d.done   = 1'b1;
                    d.status = dec_status;
                    d.err    = dec_err;
                    d.psel   = dec_psel;
                    d.poff   = dec_poff;
                    d.pfatal = dec_pfatal;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o      = q.busy;
    assign done_o      = q.done;
    assign status_o    = q.status;
    assign err_idx_o   = q.err;
    assign resp_o      = q.resp;
    assign ptr_sel_o   = q.psel;
    assign ptr_off_o   = q.poff;
    assign ptr_fatal_o = q.pfatal;

endmodule

// File: rtl/mbx_engine_chk.sv
module mbx_engine_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic [31:0]       status_o,
    input logic [4:0]        err_idx_o,
    input logic [159:0]      resp_o,
    input logic              ptr_sel_o,
    input logic              ptr_fatal_o,
    input logic              bus_req_o,
    input logic              bus_we_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic              bus_ack_i
);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !bus_req_o);

    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=>
            (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8
    ok_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o == 32'h0000_0001) |-> (err_idx_o == 5'd0));

    // R4
    tmo_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o == 32'h8000_0010) |-> (err_idx_o == 5'd5));

    // R9
    fatal_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ptr_fatal_o) |-> (resp_o[127:124] > 4'd1 && !ptr_sel_o));

endmodule

bind mbx_cmd_engine mbx_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .status_o    (status_o),
    .err_idx_o   (err_idx_o),
    .resp_o      (resp_o),
    .ptr_sel_o   (ptr_sel_o),
    .ptr_fatal_o (ptr_fatal_o),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_ack_i   (bus_ack_i)
);

// File: tb/tb_mbx_cmd_engine.sv
`timescale 1ns/1ps
module tb_mbx_cmd_engine;
    localparam int CMD_W  = 2;
    localparam int ADDR_W = 12;
    localparam int IVL    = 3;
    localparam int LIM    = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [CMD_W-1:0]  cmd_sel_i = '0;
    logic              busy_o, done_o, ptr_sel_o, ptr_fatal_o;
    logic [31:0]       status_o;
    logic [4:0]        err_idx_o;
    logic [159:0]      resp_o;
    logic [27:0]       ptr_off_o;
    logic              bus_req_o, bus_we_o;
    logic [ADDR_W-1:0] bus_addr_o;
    logic [31:0]       bus_wdata_o;
    logic [31:0]       bus_rdata_i = '0;
    logic              bus_ack_i = 1'b0;

    always #5 clk = ~clk;

    mbx_cmd_engine #(
        .CMD_W(CMD_W), .NUM_CMDS(3), .ADDR_W(ADDR_W),
        .POLL_INTERVAL(IVL), .POLL_LIMIT(LIM)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_sel_i(cmd_sel_i),
        .busy_o(busy_o), .done_o(done_o), .status_o(status_o),
        .err_idx_o(err_idx_o), .resp_o(resp_o), .ptr_sel_o(ptr_sel_o),
        .ptr_off_o(ptr_off_o), .ptr_fatal_o(ptr_fatal_o),
        .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
        .bus_ack_i(bus_ack_i)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // coprocessor model state
    logic [31:0] cap_msg [5];
    logic [31:0] rsp_w   [5];
    logic [31:0] reply_status;
    int reply_after, wr_cnt, door_cnt, door_at_wr, poll_cnt, poll_last;
    int gap_bad, fetch_cnt, ack_cnt, ack_val, fetch_at_ack, bus_cnt, order_bad;

    task automatic model_clear();
        for (int i = 0; i < 5; i++) cap_msg[i] = '0;
        wr_cnt = 0; door_cnt = 0; door_at_wr = -1; poll_cnt = 0;
        poll_last = 0; gap_bad = 0; fetch_cnt = 0; ack_cnt = 0;
        ack_val = -1; fetch_at_ack = -1; bus_cnt = 0; order_bad = 0;
    endtask

    // one-cycle acknowledge; the access takes effect at the edge that raises ack
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            bus_ack_i <= 1'b0;
        end else if (bus_req_o && !bus_ack_i) begin
            bus_ack_i <= 1'b1;
            bus_cnt = bus_cnt + 1;
            if (bus_we_o) begin
                if (bus_addr_o >= 12'h100 && bus_addr_o <= 12'h110) begin
                    if (int'(bus_addr_o - 12'h100) != 4 * wr_cnt) order_bad++;
                    cap_msg[(bus_addr_o - 12'h100) >> 2] = bus_wdata_o;
                    wr_cnt = wr_cnt + 1;
                end else if (bus_addr_o == 12'h010) begin
                    if (bus_wdata_o == 32'd1) door_cnt = door_cnt + 1;
                    door_at_wr = wr_cnt;
                end else if (bus_addr_o == 12'h014) begin
                    ack_cnt = ack_cnt + 1;
                    ack_val = int'(bus_wdata_o);
                    fetch_at_ack = fetch_cnt;
                end
            end else begin
                if (bus_addr_o == 12'h014) begin
                    // after a zero poll the bus idles IVL cycles: edges IVL+2 apart
                    if (poll_cnt > 0 && (cyc - poll_last) != IVL + 2) gap_bad++;
                    poll_last = cyc;
                    if (door_cnt > 0 && poll_cnt >= reply_after) bus_rdata_i <= reply_status;
                    else bus_rdata_i <= '0;
                    poll_cnt = poll_cnt + 1;
                end else if (bus_addr_o >= 12'h100 && bus_addr_o <= 12'h110) begin
                    if (int'(bus_addr_o - 12'h100) != 4 * fetch_cnt) order_bad++;
                    bus_rdata_i <= rsp_w[(bus_addr_o - 12'h100) >> 2];
                    fetch_cnt = fetch_cnt + 1;
                end else begin
                    bus_rdata_i <= '0;
                end
            end
        end else begin
            bus_ack_i <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // expected values from the requirements
    function automatic logic [31:0] tmpl(input int c, input int i);
        logic [31:0] op, a0;
        op = (c == 0) ? 32'd1 : 32'd2;
        a0 = (c == 2) ? 32'd2 : 32'd1;
        case (i)
            0: return 32'd1;
            1: return op;
            2: return 32'd1;
            3: return a0;
            default: return 32'd1 + op + 32'd1 + a0;
        endcase
    endfunction

    function automatic logic [4:0] ffs31(input logic [31:0] s);
        for (int i = 0; i < 31; i++) if (s[i]) return 5'(i + 1);
        return 5'd0;
    endfunction

    function automatic logic [31:0] exp_status(input logic [31:0] hb, input bit tmo);
        if (tmo) return 32'h8000_0010;
        if (rsp_w[0] + rsp_w[1] + rsp_w[2] + rsp_w[3] != rsp_w[4]) return 32'h8000_0004;
        return hb;
    endfunction

    function automatic logic [4:0] exp_idx(input logic [31:0] s);
        return (s == 32'd1) ? 5'd0 : ffs31(s);
    endfunction

    task automatic set_reply(input int c, input logic [31:0] st,
                             input logic [31:0] arg0, input bit corrupt);
        reply_status = st;
        rsp_w[0] = 32'd2;
        rsp_w[1] = tmpl(c, 1);
        rsp_w[2] = 32'd1;
        rsp_w[3] = arg0;
        rsp_w[4] = rsp_w[0] + rsp_w[1] + rsp_w[2] + rsp_w[3] + (corrupt ? 32'd1 : 32'd0);
    endtask

    task automatic wait_done(output int waited);
        waited = 0;
        while (!done_o && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        if (!done_o) chk(1'b0, "R6", "done never seen", 0, 1);
    endtask

    task automatic run_txn(input int c, input int after, input logic [31:0] st,
                           input logic [31:0] arg0, input bit corrupt);
        int waited;
        bit tmo;
        logic [31:0] es;
        model_clear();
        reply_after = after;
        set_reply(c, st, arg0, corrupt);
        tmo = (after >= LIM);
        @(negedge clk);
        start_i = 1'b1;
        cmd_sel_i = CMD_W'(c);
        @(negedge clk);
        start_i = 1'b0;
        if (c > 2) begin
            chk(done_o === 1'b1, "R10", "done one cycle after bad select", done_o, 1);
            chk(busy_o === 1'b0, "R10", "busy stays low", busy_o, 0);
            chk(status_o == 32'h8000_0002, "R10", "status", status_o, 32'h8000_0002);
            chk(err_idx_o == 5'd2, "R10", "err idx", err_idx_o, 2);
            @(negedge clk);
            chk(bus_cnt == 0, "R10", "no bus access", bus_cnt, 0);
            return;
        end
        chk(busy_o === 1'b1, "R11", "busy after start", busy_o, 1);
        wait_done(waited);
        chk(busy_o === 1'b0, "R6", "busy low with done", busy_o, 0);
        for (int i = 0; i < 5; i++)
            chk(cap_msg[i] == tmpl(c, i), "R1", $sformatf("msg word %0d", i), cap_msg[i], tmpl(c, i));
        chk(wr_cnt == 5 && order_bad == 0, "R1", "write count/order", wr_cnt, 5);
        chk(door_cnt == 1 && door_at_wr == 5, "R2", "doorbell after 5 writes", door_at_wr, 5);
        chk(gap_bad == 0, "R3", "poll spacing", gap_bad, 0);
        chk(poll_cnt == (tmo ? LIM : after + 1), "R3", "poll count", poll_cnt, tmo ? LIM : after + 1);
        chk(ack_cnt == 1 && ack_val == 0, "R6", "mailbox acknowledge write", ack_val, 0);
        chk(fetch_at_ack == fetch_cnt, "R6", "ack after reply reads", fetch_at_ack, fetch_cnt);
        es = exp_status(st, tmo);
        if (tmo) begin
            chk(status_o == 32'h8000_0010, "R4", "timeout status", status_o, 32'h8000_0010);
            chk(err_idx_o == 5'd5, "R4", "timeout idx", err_idx_o, 5);
            chk(fetch_cnt == 0 && resp_o == '0, "R4", "no reply read", fetch_cnt, 0);
            chk({ptr_sel_o, ptr_fatal_o, ptr_off_o} == '0, "R4", "ptr zero", ptr_off_o, 0);
        end else begin
            chk(fetch_cnt == 5 && order_bad == 0, "R5", "reply read count", fetch_cnt, 5);
            for (int i = 0; i < 5; i++)
                chk(resp_o[32*i +: 32] == rsp_w[i], "R5", $sformatf("reply word %0d", i),
                    resp_o[32*i +: 32], rsp_w[i]);
            if (corrupt) chk(status_o == 32'h8000_0004 && err_idx_o == 5'd3, "R7",
                             "checksum override", status_o, 32'h8000_0004);
            else chk(status_o == es, "R8", "status pass-through", status_o, es);
            chk(err_idx_o == exp_idx(es), "R8", "err idx", err_idx_o, exp_idx(es));
            chk(ptr_sel_o == (arg0[31:28] == 4'd1), "R9", "ptr sel", ptr_sel_o, arg0[31:28] == 4'd1);
            chk(ptr_fatal_o == (arg0[31:28] > 4'd1), "R9", "ptr fatal", ptr_fatal_o, arg0[31:28] > 4'd1);
            chk(ptr_off_o == arg0[27:0], "R9", "ptr offset", ptr_off_o, arg0[27:0]);
        end
    endtask

    initial begin
        int w;
        void'($urandom(32'd20240611));
        model_clear();
        reply_after = 0;
        reply_status = 32'd1;
        for (int i = 0; i < 5; i++) rsp_w[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(busy_o === 1'b0 && done_o === 1'b0, "R12", "busy/done after reset", {busy_o, done_o}, 0);
        chk(bus_req_o === 1'b0, "R12", "bus idle after reset", bus_req_o, 0);
        chk(status_o == '0 && err_idx_o == '0, "R12", "status zero", status_o, 0);

        // directed corner cases
        run_txn(0, 0, 32'd1, 32'h1000_0040, 1'b0);
        run_txn(1, 2, 32'd1, 32'h0000_0100, 1'b0);
        run_txn(2, 1, 32'd1, 32'h3000_0008, 1'b0);
        run_txn(0, LIM - 1, 32'd1, 32'h1000_0000, 1'b0);
        run_txn(1, LIM, 32'd1, 32'h1000_0000, 1'b0);
        run_txn(2, 0, 32'h8000_0008, 32'h0000_0010, 1'b1);
        run_txn(0, 0, 32'h8000_0000, 32'h0, 1'b0);
        run_txn(3, 0, 32'd1, 32'h0, 1'b0);

        // R11: start while busy is ignored
        model_clear();
        reply_after = 2;
        set_reply(0, 32'd1, 32'h1000_0004, 1'b0);
        @(negedge clk);
        start_i = 1'b1; cmd_sel_i = 2'd0;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        start_i = 1'b1; cmd_sel_i = 2'd2;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(w);
        repeat (5) @(negedge clk);
        chk(door_cnt == 1, "R11", "single doorbell despite second start", door_cnt, 1);
        chk(cap_msg[3] == tmpl(0, 3), "R11", "first command kept", cap_msg[3], tmpl(0, 3));
        chk(busy_o === 1'b0, "R11", "idle after done", busy_o, 0);

        // constrained random
        for (int n = 0; n < 40; n++) begin
            int c, after, ty;
            logic [31:0] st, a0;
            c = int'($urandom % 4);
            after = int'($urandom % (LIM + 1));
            case ($urandom % 5)
                0: st = 32'd1;
                1: st = 32'h8000_0001;
                2: st = 32'h8000_0002;
                3: st = 32'h8000_0008;
                default: st = (32'h1 << ($urandom % 31)) | ($urandom & 32'h8000_0000);
            endcase
            ty = int'($urandom % 3);
            a0 = {4'(ty == 2 ? 2 + ($urandom % 14) : ty), 28'($urandom)};
            run_txn(c, after, st, a0, ($urandom % 4) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        fails++;
        $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule